// File: doc/BRIEF.md
# Hash Engine Control Register Front End

This block sits between a 32-bit register port and a DMA-driven hash engine. Software programs a source address, a digest/state address, a key address and a byte count, then writes a command word. When the engine is idle and the command carries a recognised algorithm code, the block issues a one-cycle start to the engine. It tracks busy until the engine reports done, then sets a sticky completion flag that drives a level interrupt until software clears it.

The command word is decoded into an algorithm select and two mode bits (accumulate from the stored state, and big-endian message words). These go to the engine together with the stored addresses and length. A command whose algorithm field matches none of the four codes starts nothing and sets a sticky error flag. Software usually polls the completion bit with a timeout that grows with the job length. Every pin is a plain control or status level, because no data stream passes through this block. Register reads are combinational on the address, and writes take effect at the clock edge.

Top module: `hash_ctl_front`

## Requirements
- R1: After reset, every register reads 0, the status word is 0, `irq` is low and `eng_start` is low.
- R2: Offsets 0x20 (source address), 0x24 (digest/state address), 0x28 (key address) and 0x2C (byte length) can be written and read back at any time. Each drives its engine output directly and keeps its value across jobs. An unmapped offset reads 0.
- R3: The algorithm field is command bits {10,6,5,4}. SHA-1 is 0010, SHA-256 is 0101, SHA-384 is 1110 and SHA-512 is 0110. On `eng_alg` these appear as 0, 1, 2 and 3.
- R4: Command bit 8 drives `eng_accum` and command bit 3 drives `eng_big_endian`. An accepted command word reads back at offset 0x30.
- R5: A write to 0x30 while idle, with a valid code, raises `eng_start` for exactly the one cycle after the write. Status bit 0 (busy) is high from that same cycle until the cycle after `eng_done`.
- R6: A write to 0x30 while busy is ignored. No start is issued and the stored command is unchanged.
- R7: A command with an invalid code is stored but raises no start and leaves the block idle. It sets the sticky error flag at status bit 1.
- R8: `eng_done` while busy sets the sticky completion flag at status bit 9 in the next cycle and clears busy.
- R9: Writing 1 to status bit 9 or bit 1 clears that flag, and writing 0 leaves it unchanged. A completion that arrives in the same cycle as the clear wins.
- R10: `irq` is a level equal to the completion flag.
- R11: `eng_done` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| eng_start | output | 1 | One-cycle job start to the engine |
| eng_src_addr | output | 32 | Source data address |
| eng_dgst_addr | output | 32 | Digest/state address |
| eng_key_addr | output | 32 | Key address |
| eng_len | output | 32 | Data byte length |
| eng_alg | output | 2 | Decoded algorithm select |
| eng_accum | output | 1 | Continue from stored state |
| eng_big_endian | output | 1 | Big-endian message words |
| eng_done | input | 1 | Engine job-complete pulse |
| irq | output | 1 | Completion interrupt (level) |

## Verification
The bound checker watches four things on every cycle. A start is a single-cycle pulse that coincides with busy. Busy rises only with a start and falls only after a done. The completion flag rises only after a done that arrived while busy, and once set it stays set until a write-one clear. Other properties need register traffic and timing, so only the directed scenarios show them: the decode of each algorithm code, readback and retention of the address registers, the ignored command while busy, the invalid-code error path, and the same-cycle race between a clear and a completion.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
  localparam logic [7:0] OFS_STAT = 8'h1C;
  localparam logic [7:0] OFS_SRC  = 8'h20;
  localparam logic [7:0] OFS_DGST = 8'h24;
  localparam logic [7:0] OFS_KEY  = 8'h28;
  localparam logic [7:0] OFS_LEN  = 8'h2C;
  localparam logic [7:0] OFS_CMD  = 8'h30;

  localparam int STAT_BUSY = 0;
  localparam int STAT_ERR  = 1;
  localparam int STAT_DONE = 9;

  localparam int CMD_BE    = 3;
  localparam int CMD_ACC   = 8;

  typedef enum logic [1:0] {
    ALG_SHA1   = 2'd0,
    ALG_SHA256 = 2'd1,
    ALG_SHA384 = 2'd2,
    ALG_SHA512 = 2'd3
  } alg_e;

  typedef struct packed {
    logic valid;
    alg_e alg;
  } alg_dec_t;
endpackage

// File: rtl/hcf_alg_decode.sv
module hcf_alg_decode
  import hcf_pkg::*;
(
  input  logic [3:0] field,   // {cmd[10], cmd[6], cmd[5], cmd[4]}
  output alg_dec_t   dec
);
  always_comb begin
    dec.valid = 1'b1;
    dec.alg   = ALG_SHA1;
    unique case (field)
      4'b0010: dec.alg = ALG_SHA1;
      4'b0101: dec.alg = ALG_SHA256;
      4'b1110: dec.alg = ALG_SHA384;
      4'b0110: dec.alg = ALG_SHA512;
      default: dec.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/hcf_regfile.sv
module hcf_regfile
  import hcf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic [DW-1:0] status,
  output logic [DW-1:0] src_q,
  output logic [DW-1:0] dgst_q,
  output logic [DW-1:0] key_q,
  output logic [DW-1:0] len_q,
  output logic [DW-1:0] cmd_q,
  output logic          cmd_accept,
  output logic          stat_wr,
  output logic [DW-1:0] rdata
);
  localparam int NREG = 4;

  logic [NREG-1:0][AW-1:0] ofs;
  logic [NREG-1:0][DW-1:0] regs_q;

  assign ofs[0] = AW'(OFS_SRC);
  assign ofs[1] = AW'(OFS_DGST);
  assign ofs[2] = AW'(OFS_KEY);
  assign ofs[3] = AW'(OFS_LEN);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        regs_q[g] <= '0;
      else if (wr_en && addr == ofs[g])  regs_q[g] <= wdata;
    end
  end

  assign cmd_accept = wr_en && (addr == AW'(OFS_CMD)) && !busy;
  assign stat_wr    = wr_en && (addr == AW'(OFS_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cmd_q <= '0;
    else if (cmd_accept) cmd_q <= wdata;
  end

  assign src_q  = regs_q[0];
  assign dgst_q = regs_q[1];
  assign key_q  = regs_q[2];
  assign len_q  = regs_q[3];

  always_comb begin
    rdata = '0;
    if (addr == AW'(OFS_STAT))     rdata = status;
    else if (addr == AW'(OFS_CMD)) rdata = cmd_q;
    else begin
      for (int i = 0; i < NREG; i++)
        if (addr == ofs[i]) rdata = regs_q[i];
    end
  end
endmodule

// File: rtl/hcf_job_ctrl.sv
module hcf_job_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_accept,
  input  logic cmd_ok,
  input  logic clr_done,
  input  logic clr_err,
  input  logic eng_done,
  output logic eng_start,
  output logic busy,
  output logic done_flag,
  output logic err_flag
);
  logic finish;
  assign finish = busy && eng_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_start <= 1'b0;
      busy      <= 1'b0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      eng_start <= cmd_accept && cmd_ok;
      if (cmd_accept && cmd_ok) busy <= 1'b1;
      else if (finish)          busy <= 1'b0;
      if (finish)        done_flag <= 1'b1;
      else if (clr_done) done_flag <= 1'b0;
      if (cmd_accept && !cmd_ok) err_flag <= 1'b1;
      else if (clr_err)          err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/hash_ctl_front.sv
module hash_ctl_front
  import hcf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          eng_start,
  output logic [DW-1:0] eng_src_addr,
  output logic [DW-1:0] eng_dgst_addr,
  output logic [DW-1:0] eng_key_addr,
  output logic [DW-1:0] eng_len,
  output logic [1:0]    eng_alg,
  output logic          eng_accum,
  output logic          eng_big_endian,
  input  logic          eng_done,
  output logic          irq
);
  logic          busy, done_flag, err_flag;
  logic          cmd_accept, stat_wr;
  logic [DW-1:0] cmd_q, status;
  alg_dec_t      wr_dec, cur_dec;

  always_comb begin
    status            = '0;
    status[STAT_BUSY] = busy;
    status[STAT_ERR]  = err_flag;
    status[STAT_DONE] = done_flag;
  end

  hcf_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy(busy), .status(status),
    .src_q(eng_src_addr), .dgst_q(eng_dgst_addr), .key_q(eng_key_addr),
    .len_q(eng_len), .cmd_q(cmd_q),
    .cmd_accept(cmd_accept), .stat_wr(stat_wr), .rdata(rdata)
  );

  // incoming word decides whether a start is issued
  hcf_alg_decode u_dec_wr (
    .field({wdata[10], wdata[6], wdata[5], wdata[4]}), .dec(wr_dec)
  );

  // stored word drives the engine select
  hcf_alg_decode u_dec_cur (
    .field({cmd_q[10], cmd_q[6], cmd_q[5], cmd_q[4]}), .dec(cur_dec)
  );

  hcf_job_ctrl u_job (
    .clk(clk), .rst_n(rst_n),
    .cmd_accept(cmd_accept), .cmd_ok(wr_dec.valid),
    .clr_done(stat_wr && wdata[STAT_DONE]),
    .clr_err(stat_wr && wdata[STAT_ERR]),
    .eng_done(eng_done),
    .eng_start(eng_start), .busy(busy),
    .done_flag(done_flag), .err_flag(err_flag)
  );

  assign eng_alg        = cur_dec.alg;
  assign eng_accum      = cmd_q[CMD_ACC];
  assign eng_big_endian = cmd_q[CMD_BE];
  assign irq            = done_flag;
endmodule

// File: rtl/hash_ctl_front_chk.sv
module hash_ctl_front_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          eng_start,
  input logic          eng_done,
  input logic          busy,
  input logic          irq
);
  // R5
  start_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);
  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> eng_start);
  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(eng_done));
  // R11
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(busy && eng_done));
  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == AW'(8'h1C) && wdata[9])) |=> irq);
endmodule

bind hash_ctl_front hash_ctl_front_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .eng_start(eng_start), .eng_done(eng_done), .busy(busy), .irq(irq)
);

// File: tb/hash_ctl_front_tb.sv
module hash_ctl_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, src, dgst, key, len;
  logic        eng_start, eng_accum, eng_be, eng_done, irq;
  logic [1:0]  eng_alg;
  logic        extra_done = 1'b0;
  int          stub_dly = 5;
  int          stub_cnt = 0;
  int          n_chk = 0, n_bad = 0;
  bit          over = 1'b0;

  always #10 clk = ~clk;

  hash_ctl_front u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .eng_start(eng_start), .eng_src_addr(src),
    .eng_dgst_addr(dgst), .eng_key_addr(key), .eng_len(len),
    .eng_alg(eng_alg), .eng_accum(eng_accum), .eng_big_endian(eng_be),
    .eng_done(eng_done), .irq(irq)
  );

  // engine stub: done pulse stub_dly cycles after start
  always @(posedge clk) begin
    if (eng_start)         stub_cnt <= stub_dly;
    else if (stub_cnt > 0) stub_cnt <= stub_cnt - 1;
  end
  assign eng_done = (stub_cnt == 1) || extra_done;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp,
                           input string req);
    logic [31:0] v;
    reg_rd(a, v);
    check(v === exp, req, v, exp);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 1000; i++) begin
      reg_rd(8'h1C, v);
      if (!v[0]) return;
      @(negedge clk);
    end
    check(1'b0, "R8 idle timeout", v, 32'h0);
  endtask

  task automatic t_reset();
    expect_rd(8'h1C, 32'h0, "R1 status");
    expect_rd(8'h20, 32'h0, "R1 src");
    expect_rd(8'h2C, 32'h0, "R1 len");
    expect_rd(8'h30, 32'h0, "R1 cmd");
    check(!irq && !eng_start, "R1 irq/start", {irq, eng_start}, 0);
  endtask

  task automatic t_regs();
    reg_wr(8'h20, 32'h1000_0040);
    reg_wr(8'h24, 32'h2000_0080);
    reg_wr(8'h28, 32'h3000_00C0);
    reg_wr(8'h2C, 32'd128);
    expect_rd(8'h20, 32'h1000_0040, "R2 src rb");
    expect_rd(8'h24, 32'h2000_0080, "R2 dgst rb");
    expect_rd(8'h28, 32'h3000_00C0, "R2 key rb");
    expect_rd(8'h2C, 32'd128, "R2 len rb");
    check(src == 32'h1000_0040 && dgst == 32'h2000_0080 &&
          key == 32'h3000_00C0 && len == 32'd128, "R2 engine outs", src, 32'h1000_0040);
    expect_rd(8'h34, 32'h0, "R2 unmapped");
  endtask

  // SHA-256, accumulate, big-endian; second command while busy
  task automatic t_job();
    logic [31:0] v;
    stub_dly = 8;
    reg_wr(8'h30, 32'h0000_0158);
    check(eng_start === 1'b1, "R5 start pulse", eng_start, 1);
    expect_rd(8'h1C, 32'h1, "R5 busy");
    check(eng_alg == 2'd1 && eng_accum && eng_be, "R3 R4 sha256 accum be",
          {eng_alg, eng_accum, eng_be}, 4'b0111);
    @(negedge clk);
    check(eng_start === 1'b0, "R5 start width", eng_start, 0);
    reg_wr(8'h30, 32'h0000_0020);
    check(eng_start === 1'b0, "R6 no restart", eng_start, 0);
    expect_rd(8'h30, 32'h0000_0158, "R6 cmd kept");
    for (int i = 0; i < 50 && !eng_done; i++) @(negedge clk);
    check(irq === 1'b0, "R8 not yet", irq, 0);
    expect_rd(8'h1C, 32'h1, "R5 busy until done");
    @(negedge clk);
    check(irq === 1'b1, "R10 irq level", irq, 1);
    expect_rd(8'h1C, 32'h200, "R8 done flag");
    repeat (10) @(negedge clk);
    expect_rd(8'h1C, 32'h200, "R8 sticky");
    reg_wr(8'h1C, 32'h0000_0001);
    expect_rd(8'h1C, 32'h200, "R9 write zero to bit9");
    reg_wr(8'h1C, 32'h0000_0200);
    reg_rd(8'h1C, v);
    check(v == 32'h0 && !irq, "R9 R10 clear", v, 0);
  endtask

  task automatic t_algs();
    logic [31:0] codes[4] = '{32'h020, 32'h050, 32'h460, 32'h060};
    stub_dly = 3;
    for (int k = 0; k < 4; k++) begin
      reg_wr(8'h30, codes[k]);
      check(eng_start && eng_alg == 2'(k) && !eng_accum && !eng_be,
            "R3 alg code", {30'b0, eng_alg}, k);
      wait_idle();
      reg_wr(8'h1C, 32'h200);
    end
  endtask

  task automatic t_invalid();
    reg_wr(8'h30, 32'h0000_0410);
    check(eng_start === 1'b0, "R7 no start", eng_start, 0);
    expect_rd(8'h1C, 32'h2, "R7 err not busy");
    expect_rd(8'h30, 32'h0000_0410, "R7 stored");
    @(negedge clk);
    expect_rd(8'h1C, 32'h2, "R7 err sticky");
    reg_wr(8'h1C, 32'h2);
    expect_rd(8'h1C, 32'h0, "R9 err clear");
  endtask

  task automatic t_idle_done();
    @(negedge clk); extra_done = 1'b1;
    @(negedge clk); extra_done = 1'b0;
    @(negedge clk);
    check(irq === 1'b0, "R11 idle done irq", irq, 0);
    expect_rd(8'h1C, 32'h0, "R11 idle done status");
  endtask

  task automatic t_race();
    stub_dly = 60;
    reg_wr(8'h30, 32'h0000_0060);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h1C; wdata = 32'h200; extra_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; extra_done = 1'b0;
    check(irq === 1'b1, "R9 set wins", irq, 1);
    reg_wr(8'h1C, 32'h200);
    check(irq === 1'b0, "R9 clear after race", irq, 0);
    expect_rd(8'h20, 32'h1000_0040, "R2 held across jobs");
    expect_rd(8'h2C, 32'd128, "R2 len held");
  endtask

  initial begin
    #(20 * 150000);
    if (!over) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_job();
    t_algs();
    t_invalid();
    t_idle_done();
    t_race();
    over = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule